// File: doc/BRIEF.md
# Symbol-Aligned Receive Clock-Enable Divider

The block sits on the receive side of a 100 Mbit/s copper port. It runs on the recovered line clock, which ticks once per received symbol, and produces a one-cycle clock enable every DIV cycles (five by default) to pace the 4-bit receive interface. A free-running divider of this kind locks to an arbitrary phase each time the link comes up. That adds an unknown receive latency of zero to DIV-1 line-clock periods, which is up to 32 ns at 125 MHz. Because this latency changes from one link establishment to the next, a timing engine cannot calibrate it out once and rely on the result.

The block fixes the divider phase to a symbol-boundary strobe supplied by the decoder. The first boundary strobe seen with the link up is taken as phase zero of the divider. The block records how far the free-running divider was from that boundary, so that software or a timestamp corrector can account for it. While the link stays up, later strobes that arrive on phase zero confirm the alignment. A strobe that arrives on any other phase is treated as a slip: the divider realigns and a sticky flag is raised. Dropping the link clears all alignment state.

Top module: `sym_mii_clkdiv`

## Requirements
- R1: While reset is held, and in the first cycle after it, `mii_ce` is 1 and `aligned`, `slip` and `phase_idx` are 0.
- R2: `mii_ce` is high for exactly one cycle in every DIV cycles and is never high in two consecutive cycles. It runs freely whether or not the link is up.
- R3: When the divider accepts a boundary strobe in cycle T, it treats cycle T as phase zero. `mii_ce` is then next high in cycle T+DIV and every DIV cycles after that.
- R4: When a strobe is accepted, `phase_idx` takes, from the following cycle, the number of cycles that elapsed since the last `mii_ce` at the strobe cycle. This is 0 if `mii_ce` was high in that cycle, and the value always lies in 0..DIV-1.
- R5: `aligned` rises in the cycle after the first strobe that arrives with `link_up` high. It falls in the cycle after `link_up` is sampled low.
- R6: Strobes that arrive while `link_up` is low have no effect: `aligned` stays 0, `phase_idx` stays 0 and the enable cadence is unchanged.
- R7: A strobe that arrives while the block is aligned and in a cycle where `mii_ce` is high is ignored: `phase_idx` holds, `slip` holds and the cadence is unchanged.
- R8: A strobe that arrives while the block is aligned and in a cycle where `mii_ce` is low sets `slip` in the following cycle. The block realigns as in R3 and records the phase as in R4, and `slip` stays set while `link_up` stays high.
- R9: Sampling `link_up` low clears `slip` and `phase_idx` to 0 in the following cycle.
- R10: DIV must be at least 2. `phase_idx` is `$clog2(DIV)` bits wide, with a minimum of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered line clock, one cycle per symbol |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up | input | 1 | High while the link is established |
| sym_bound | input | 1 | One-cycle strobe on a symbol-group boundary |
| mii_ce | output | 1 | Receive-interface clock enable, one cycle in DIV |
| phase_idx | output | PW | Divider phase observed at the last accepted strobe |
| aligned | output | 1 | Divider is locked to the boundary strobe |
| slip | output | 1 | Sticky: a boundary strobe arrived off phase while aligned |

## Verification
The assertions assume that `sym_bound` is a synchronous strobe, and they place no constraint on how often it pulses. They also assume that `link_up` may change in any cycle, with no settling period, and that reset is released away from the clock edge. The stimulus drives every input on the falling edge. It places strobes on chosen divider phases by tracking the bench's own cycle count, covering each phase 0..DIV-1 on a fresh link, strobes on phase, strobes off phase, and strobes during link-down. It then applies a pseudo-random mix of link drops and strobes that stays within these same assumptions.

// File: rtl/sym_div_pkg.sv
package sym_div_pkg;

   typedef enum logic [0:0] {
      ST_HUNT = 1'b0,
      ST_LOCK = 1'b1
   } align_st_e;

   function automatic int phase_width(input int div);
      return (div <= 2) ? 1 : $clog2(div);
   endfunction

endpackage

// File: rtl/sym_div_counter.sv
module sym_div_counter #(
   parameter  int DIV    = 5,
   parameter  bit CE_REG = 1'b1,
   localparam int PW     = sym_div_pkg::phase_width(DIV)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   output logic [PW-1:0] cnt,
   output logic          ce
);

   localparam logic [PW-1:0] LAST = PW'(DIV - 1);
   localparam logic [PW-1:0] ONE  = PW'(1);

   generate
      if (DIV < 2) begin : g_bad_div
         $error("sym_div_counter: DIV must be at least 2");
      end
   endgenerate

   logic [PW-1:0] cnt_q;
   logic [PW-1:0] cnt_nxt;

   always_comb begin
      if (load)
         cnt_nxt = ONE;
      else if (cnt_q == LAST)
         cnt_nxt = '0;
      else
         cnt_nxt = cnt_q + ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else
         cnt_q <= cnt_nxt;
   end

   assign cnt = cnt_q;

   generate
      if (CE_REG) begin : g_ce_reg
         logic ce_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ce_q <= 1'b1;
            else
               ce_q <= (cnt_nxt == '0);
         end
         assign ce = ce_q;
      end else begin : g_ce_dec
         assign ce = (cnt_q == '0);
      end
   endgenerate

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);                                              // R2
   AST_CE_NO_B2B: assert property (@(posedge clk) disable iff (!rst_n)
      ce |=> !ce);                                                 // R2
   AST_CE_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ce == (cnt_q == '0));                                        // R2
   AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt_q == ONE) && !ce);                             // R3

endmodule

// File: rtl/sym_align_ctrl.sv
module sym_align_ctrl #(
   parameter  int DIV = 5,
   localparam int PW  = sym_div_pkg::phase_width(DIV)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          link_up,
   input  logic          sym_bound,
   input  logic [PW-1:0] cnt,
   output logic          load,
   output logic          aligned,
   output logic [PW-1:0] phase,
   output logic          slip
);

   import sym_div_pkg::*;

   localparam logic [PW-1:0] LAST = PW'(DIV - 1);

   align_st_e     state_q;
   logic [PW-1:0] phase_q;
   logic          slip_q;
   logic          off_phase;

   assign off_phase = (cnt != '0);
   assign load      = link_up && sym_bound && ((state_q == ST_HUNT) || off_phase);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_HUNT;
         phase_q <= '0;
         slip_q  <= 1'b0;
      end else if (!link_up) begin
         state_q <= ST_HUNT;
         phase_q <= '0;
         slip_q  <= 1'b0;
      end else if (load) begin
         state_q <= ST_LOCK;
         phase_q <= cnt;
         if (state_q == ST_LOCK)
            slip_q <= 1'b1;
      end
   end

   assign aligned = (state_q == ST_LOCK);
   assign phase   = phase_q;
   assign slip    = slip_q;

   AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      phase_q <= LAST);                                            // R4
   AST_PHASE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (link_up && sym_bound && !aligned) |=> (phase_q == $past(cnt)));  // R4
   AST_FIRST_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (link_up && sym_bound) |=> aligned);                         // R5
   AST_DROP_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      !link_up |=> !aligned);                                      // R5
   AST_DOWN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (!link_up && sym_bound) |=> (phase_q == '0));                // R6
   AST_ON_PHASE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (link_up && sym_bound && aligned && !off_phase) |=> ($stable(phase_q) && $stable(slip_q)));  // R7
   AST_SLIP_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (link_up && sym_bound && aligned && off_phase) |=> slip_q);  // R8
   AST_SLIP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (slip_q && link_up) |=> slip_q);                             // R8
   AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !link_up |=> (!slip_q && phase_q == '0));                    // R9

endmodule

// File: rtl/sym_mii_clkdiv.sv
module sym_mii_clkdiv #(
   parameter  int DIV    = 5,
   parameter  bit CE_REG = 1'b1,
   localparam int PW     = sym_div_pkg::phase_width(DIV)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          link_up,
   input  logic          sym_bound,
   output logic          mii_ce,
   output logic [PW-1:0] phase_idx,
   output logic          aligned,
   output logic          slip
);

   generate
      if (DIV < 2) begin : g_bad_div
         $error("sym_mii_clkdiv: DIV must be at least 2 (R10)");
      end
      if (PW < 1) begin : g_bad_pw
         $error("sym_mii_clkdiv: phase width must be at least 1 (R10)");
      end
   endgenerate

   logic [PW-1:0] cnt;
   logic          load;

   sym_div_counter #(
      .DIV    (DIV),
      .CE_REG (CE_REG)
   ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .cnt   (cnt),
      .ce    (mii_ce)
   );

   sym_align_ctrl #(
      .DIV (DIV)
   ) u_align (
      .clk       (clk),
      .rst_n     (rst_n),
      .link_up   (link_up),
      .sym_bound (sym_bound),
      .cnt       (cnt),
      .load      (load),
      .aligned   (aligned),
      .phase     (phase_idx),
      .slip      (slip)
   );

   AST_ALIGNED_ONLY_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (aligned && !$past(aligned)) |-> $past(link_up));            // R5

endmodule

// File: tb/sym_mii_clkdiv_tb.sv
`timescale 1ns/1ps
module sym_mii_clkdiv_tb;

   localparam int DIV    = 5;
   localparam int PW     = (DIV <= 2) ? 1 : $clog2(DIV);
   localparam int WD_CYC = 200000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          link_up = 1'b0;
   logic          sym_bound = 1'b0;
   logic          mii_ce;
   logic [PW-1:0] phase_idx;
   logic          aligned;
   logic          slip;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   sym_mii_clkdiv #(.DIV(DIV)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .link_up   (link_up),
      .sym_bound (sym_bound),
      .mii_ce    (mii_ce),
      .phase_idx (phase_idx),
      .aligned   (aligned),
      .slip      (slip)
   );

   typedef struct {
      logic    ce;
      logic    al;
      int      ph;
      logic    sl;
   } exp_t;

   exp_t exp_q[$];

   // bench model state: the phase the design sees at the next rising edge
   int   m_cnt = 0;
   logic m_al  = 1'b0;
   int   m_ph  = 0;
   logic m_sl  = 1'b0;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // driver: apply inputs, predict, push expected, move to next falling edge
   task automatic step(input logic lu, input logic sb);
      exp_t e;
      link_up   = lu;
      sym_bound = sb;
      if (!lu) begin
         m_cnt = (m_cnt + 1) % DIV;
         m_al  = 1'b0;
         m_ph  = 0;
         m_sl  = 1'b0;
      end else if (sb && (!m_al || m_cnt != 0)) begin
         m_ph  = m_cnt;
         m_sl  = m_sl | m_al;
         m_al  = 1'b1;
         m_cnt = 1 % DIV;
      end else begin
         m_cnt = (m_cnt + 1) % DIV;
      end
      e.ce = (m_cnt == 0);
      e.al = m_al;
      e.ph = m_ph;
      e.sl = m_sl;
      exp_q.push_back(e);
      @(negedge clk);
   endtask

   task automatic idle(input logic lu, input int n);
      for (int i = 0; i < n; i++) step(lu, 1'b0);
   endtask

   task automatic strobe_at(input logic lu, input int p);
      while (m_cnt != p) step(lu, 1'b0);
      step(lu, 1'b1);
   endtask

   // monitor: compare outputs just after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk("R2 R3 mii_ce cadence", int'(mii_ce), int'(e.ce));
            chk("R5 aligned", int'(aligned), int'(e.al));
            chk("R4 phase_idx", int'(phase_idx), e.ph);
            chk("R8 slip", int'(slip), int'(e.sl));
         end
      end
   end

   initial begin
      #(WD_CYC * 4);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] lfsr;
      int          ce_cnt;
      chk("R10 phase_idx width", $bits(phase_idx), PW);
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk("R1 reset mii_ce", int'(mii_ce), 1);
      chk("R1 reset aligned", int'(aligned), 0);
      chk("R1 reset phase_idx", int'(phase_idx), 0);
      chk("R1 reset slip", int'(slip), 0);
      rst_n = 1'b1;

      // R2 free-running with link down, count enables over 4*DIV cycles
      ce_cnt = 0;
      for (int i = 0; i < 4 * DIV; i++) begin
         step(1'b0, 1'b0);
         ce_cnt += int'(mii_ce);
      end
      chk("R2 enables per 4*DIV cycles", ce_cnt, 4);

      // R6 strobes with link down have no effect
      for (int i = 0; i < DIV; i++) step(1'b0, 1'b1);
      chk("R6 aligned after down strobes", int'(aligned), 0);
      chk("R6 phase after down strobes", int'(phase_idx), 0);

      // R3 R4 R5 first alignment on phase 3
      idle(1'b1, 2);
      chk("R5 not aligned before strobe", int'(aligned), 0);
      strobe_at(1'b1, 3);
      chk("R5 aligned after first strobe", int'(aligned), 1);
      chk("R4 phase recorded", int'(phase_idx), 3);
      for (int i = 1; i < DIV; i++) begin
         chk("R3 no enable inside group", int'(mii_ce), 0);
         step(1'b1, 1'b0);
      end
      chk("R3 enable DIV cycles after strobe", int'(mii_ce), 1);

      // R7 on-phase strobes ignored
      for (int k = 0; k < 4; k++) strobe_at(1'b1, 0);
      chk("R7 slip stays low", int'(slip), 0);
      chk("R7 phase held", int'(phase_idx), 3);

      // R8 off-phase strobe
      strobe_at(1'b1, 2);
      chk("R8 slip set", int'(slip), 1);
      chk("R8 phase records slip", int'(phase_idx), 2);
      idle(1'b1, 2 * DIV);
      chk("R8 slip sticky", int'(slip), 1);
      strobe_at(1'b1, 0);
      chk("R8 slip held on phase", int'(slip), 1);

      // R9 link drop clears
      step(1'b0, 1'b0);
      chk("R9 slip cleared", int'(slip), 0);
      chk("R9 phase cleared", int'(phase_idx), 0);
      chk("R5 aligned cleared", int'(aligned), 0);

      // R4 every phase on a fresh link
      for (int p = 0; p < DIV; p++) begin
         idle(1'b0, 3);
         strobe_at(1'b1, p);
         chk("R4 fresh-link phase", int'(phase_idx), p);
         chk("R8 no slip on first lock", int'(slip), 0);
         idle(1'b1, DIV + 1);
      end

      // mixed pseudo-random traffic
      lfsr = 16'hACE1;
      for (int i = 0; i < 600; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(lfsr[7:3] != 5'd0, lfsr[1:0] == 2'd0);
      end

      idle(1'b1, 2);
      @(posedge clk);
      #2;
      chk("scoreboard drained", exp_q.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule